// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words (1 sign bit, 8-bit biased exponent, 23-bit fraction, bias 127). It runs as a three-stage pipeline. The first stage sorts each operand into a class (NaN, infinity, zero, subnormal or normal) and adds the two exponents with the bias taken out. The second stage forms the full 24 x 24 bit significand product. The third stage normalizes the 48-bit product, reduces the dropped bits to guard, round and sticky, rounds in the selected mode, checks the exponent range, sets the sign and packs the word.

A new operation can be issued on every clock cycle by raising `in_valid` with the operands and a rounding mode. Exactly three clock edges later the result comes out with a one-cycle `out_valid` pulse and three status flags. The block has no back-pressure. Any result that falls below the normal exponent range is flushed to a signed zero. Subnormal operands are accepted: their hidden bit is 0 and their exponent is taken as 1.

Top module: `fp32_mul_core`

## Requirements
- R1: `out_valid` rises exactly three rising clock edges after the edge that samples `in_valid` high. There is one output pulse for each accepted operation. While reset is held, `out_valid`, `result` and all flags are 0.
- R2: With `rnd_mode` = 0 (nearest, ties to even), a finite nonzero product in range is the exact product of the two values rounded to 24 significant bits. An exact halfway case goes to the candidate whose lowest significand bit is 0.
- R3: `rnd_mode` = 1 truncates toward zero. `rnd_mode` = 2 rounds toward positive infinity. `rnd_mode` = 3 rounds toward negative infinity. In each mode the decision uses every bit that lies below the kept significand.
- R4: For every non-NaN result, the sign bit (bit 31) is the XOR of the two operand sign bits. This holds for zero and infinite results too.
- R5: If the rounded biased exponent is 255 or more, `flag_ovf` is set and the result is one of two values. It is infinity (exponent field 255, fraction 0) in mode 0, and in the directed mode whose direction matches the sign. Otherwise it is the largest finite magnitude (exponent 254, fraction all ones).
- R6: If the rounded biased exponent of a finite nonzero product is 0 or less, `flag_unf` is set and the result is a zero carrying the product sign.
- R7: If either operand is a NaN (exponent 255, fraction nonzero), the result is the quiet NaN 0x7FC00000 and no flag is set.
- R8: Zero times infinity, in either order and with any signs, gives 0x7FC00000 with `flag_inv` set.
- R9: An operand with exponent field 0 and a nonzero fraction is treated as 0.fraction x 2^-126. The product is fully renormalized, so the result can again be a normal number.
- R10: All three flags are 0 in every cycle where `out_valid` is 0. At most one flag is set at a time.
- R11: Zero times a finite number gives a signed zero with no flag set. Infinity times a nonzero non-NaN number gives a signed infinity with no flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| rnd_mode | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| out_valid | output | 1 | Result and flags are valid this cycle |
| result | output | 32 | Product word |
| flag_ovf | output | 1 | Exponent above range |
| flag_unf | output | 1 | Exponent below normal range, flushed to zero |
| flag_inv | output | 1 | Zero multiplied by infinity |

## Verification
Several properties are checked on every cycle. These cover the three-edge latency between `in_valid` and `out_valid`, flags staying quiet between results and never being set together, and the result shape that each flag implies (NaN word for invalid, zero magnitude for underflow, saturated or infinite exponent for overflow). They also check the sign of every non-NaN result against the operand signs seen three edges earlier. Only the bench's scenarios can show that the significand is correctly rounded. That covers halfway ties in nearest-even, the directed modes on both signs, the rounding carry that bumps the exponent, and renormalization of products from subnormal operands. The bench compares each output against an independent model based on remainder-versus-half comparisons.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int ESUM_W = EXP_W + 3;
  localparam int LZ_W   = $clog2(PROD_W + 1);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MX = (1 << EXP_W) - 1;

  localparam logic signed [ESUM_W-1:0] BIAS_S = ESUM_W'(BIAS);
  localparam logic signed [ESUM_W-1:0] ETOP_S = ESUM_W'(EXP_MX);
  localparam logic signed [ESUM_W-1:0] ONE_S  = ESUM_W'(1);

  localparam logic [WORD_W-1:0] QNAN_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_TO_POS    = 2'd2,
    RM_TO_NEG    = 2'd3
  } rmode_e;

  // per-operand classification
  typedef struct packed {
    logic              sign;
    logic              is_nan;
    logic              is_inf;
    logic              is_zero;
    logic [EXP_W-1:0]  eff_exp;
    logic [SIG_W-1:0]  sig;
  } opnd_t;

  // control that travels with an operation down the pipe
  typedef struct packed {
    logic                     sign;
    logic                     nan;
    logic                     inv;
    logic                     inf;
    logic                     zero;
    logic signed [ESUM_W-1:0] esum;
    rmode_e                   mode;
  } opctl_t;

  function automatic opnd_t classify(input logic [WORD_W-1:0] w);
    opnd_t o;
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;
    e = w[WORD_W-2 -: EXP_W];
    f = w[FRAC_W-1:0];
    o.sign    = w[WORD_W-1];
    o.is_nan  = (e == EXP_W'(EXP_MX)) && (f != '0);
    o.is_inf  = (e == EXP_W'(EXP_MX)) && (f == '0);
    o.is_zero = (e == '0) && (f == '0);
    o.eff_exp = (e == '0) ? EXP_W'(1) : e;
    o.sig     = {(e != '0), f};
    return o;
  endfunction

  // biased exponent of the product whose significand has its units bit at PROD_W-2
  function automatic logic signed [ESUM_W-1:0] exp_sum(input logic [EXP_W-1:0] ea,
                                                       input logic [EXP_W-1:0] eb);
    logic signed [ESUM_W-1:0] xa, xb;
    xa = ESUM_W'(ea);
    xb = ESUM_W'(eb);
    return xa + xb - BIAS_S;
  endfunction

  function automatic logic [LZ_W-1:0] lead_zeros(input logic [PROD_W-1:0] p);
    logic [LZ_W-1:0] n;
    n = LZ_W'(PROD_W);
    for (int i = 0; i < PROD_W; i++) begin
      if (p[i]) n = LZ_W'(PROD_W - 1 - i);
    end
    return n;
  endfunction

  function automatic logic round_up(input logic lsb, input logic g, input logic r,
                                    input logic s, input logic sign, input rmode_e m);
    logic inexact;
    inexact = g | r | s;
    case (m)
      RM_NEAR_EVEN: return g & (r | s | lsb);
      RM_TO_ZERO:   return 1'b0;
      RM_TO_POS:    return inexact & ~sign;
      default:      return inexact & sign;
    endcase
  endfunction

  function automatic logic ovf_to_inf(input logic sign, input rmode_e m);
    return (m == RM_NEAR_EVEN) || (m == RM_TO_POS && !sign) || (m == RM_TO_NEG && sign);
  endfunction
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  rmode_e            mode,
  output logic              s1_valid,
  output opctl_t            s1_ctl,
  output logic [SIG_W-1:0]  s1_sig_a,
  output logic [SIG_W-1:0]  s1_sig_b
);
  localparam int N_OPS = 2;

  logic [WORD_W-1:0] ops [N_OPS];
  opnd_t             cls [N_OPS];
  opctl_t            ctl_d;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  generate
    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
      assign cls[gi] = classify(ops[gi]);
    end
  endgenerate

  always_comb begin
    ctl_d      = '0;
    ctl_d.sign = cls[0].sign ^ cls[1].sign;
    ctl_d.nan  = cls[0].is_nan | cls[1].is_nan;
    ctl_d.inv  = !ctl_d.nan && ((cls[0].is_inf && cls[1].is_zero) ||
                                (cls[0].is_zero && cls[1].is_inf));
    ctl_d.inf  = !ctl_d.nan && !ctl_d.inv && (cls[0].is_inf | cls[1].is_inf);
    ctl_d.zero = !ctl_d.nan && !ctl_d.inv && (cls[0].is_zero | cls[1].is_zero);
    ctl_d.esum = exp_sum(cls[0].eff_exp, cls[1].eff_exp);
    ctl_d.mode = mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_ctl   <= '0;
      s1_sig_a <= '0;
      s1_sig_b <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_ctl   <= ctl_d;
        s1_sig_a <= cls[0].sig;
        s1_sig_b <= cls[1].sig;
      end
    end
  end
endmodule

// File: rtl/fpm_sigmul.sv
module fpm_sigmul
  import fpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  opctl_t            s1_ctl,
  input  logic [SIG_W-1:0]  s1_sig_a,
  input  logic [SIG_W-1:0]  s1_sig_b,
  output logic              s2_valid,
  output opctl_t            s2_ctl,
  output logic [PROD_W-1:0] s2_prod
);
  logic [PROD_W-1:0] prod_d;

  assign prod_d = PROD_W'(s1_sig_a) * PROD_W'(s1_sig_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_ctl   <= '0;
      s2_prod  <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_ctl  <= s1_ctl;
        s2_prod <= prod_d;
      end
    end
  end
endmodule

// File: rtl/fpm_round_pack.sv
module fpm_round_pack
  import fpm_pkg::*;
(
  input  opctl_t            ctl,
  input  logic [PROD_W-1:0] prod,
  output logic [WORD_W-1:0] res_word,
  output logic              ovf_evt,
  output logic              unf_evt,
  output logic              inv_evt,
  output logic              nan_evt
);
  localparam int KEEP_LO = PROD_W - SIG_W;

  logic [LZ_W-1:0]          lz;
  logic signed [ESUM_W-1:0] lz_s, e_norm, e_fin;
  logic [PROD_W-1:0]        shifted;
  logic [SIG_W-1:0]         kept;
  logic                     g_bit, r_bit, s_bit, inc;
  logic [SIG_W:0]           sum;
  logic [SIG_W-1:0]         mant;
  logic                     finite_nz;

  always_comb begin
    lz      = lead_zeros(prod);
    lz_s    = ESUM_W'(lz);
    shifted = prod << lz;
    e_norm  = ctl.esum + ONE_S - lz_s;
    kept    = shifted[PROD_W-1 -: SIG_W];
    g_bit   = shifted[KEEP_LO-1];
    r_bit   = shifted[KEEP_LO-2];
    s_bit   = |shifted[KEEP_LO-3:0];
    inc     = round_up(kept[0], g_bit, r_bit, s_bit, ctl.sign, ctl.mode);
    sum     = {1'b0, kept} + (SIG_W+1)'(inc);
    if (sum[SIG_W]) begin
      mant  = sum[SIG_W:1];
      e_fin = e_norm + ONE_S;
    end else begin
      mant  = sum[SIG_W-1:0];
      e_fin = e_norm;
    end
  end

  assign finite_nz = !ctl.nan && !ctl.inv && !ctl.inf && !ctl.zero;
  assign nan_evt   = ctl.nan;
  assign inv_evt   = ctl.inv;
  assign ovf_evt   = finite_nz && (e_fin >= ETOP_S);
  assign unf_evt   = finite_nz && (e_fin[ESUM_W-1] || e_fin == '0);

  always_comb begin
    if (ctl.nan || ctl.inv) begin
      res_word = QNAN_WORD;
    end else if (ctl.inf) begin
      res_word = {ctl.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (ctl.zero || unf_evt) begin
      res_word = {ctl.sign, {(WORD_W-1){1'b0}}};
    end else if (ovf_evt) begin
      if (ovf_to_inf(ctl.sign, ctl.mode))
        res_word = {ctl.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else
        res_word = {ctl.sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    end else begin
      res_word = {ctl.sign, e_fin[EXP_W-1:0], mant[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/fp32_mul_core.sv
module fp32_mul_core
  import fpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [1:0]  rnd_mode,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        flag_ovf,
  output logic        flag_unf,
  output logic        flag_inv
);
  logic              s1_valid, s2_valid;
  opctl_t            s1_ctl, s2_ctl;
  logic [SIG_W-1:0]  s1_sig_a, s1_sig_b;
  logic [PROD_W-1:0] s2_prod;
  logic [WORD_W-1:0] res_word;
  logic              ovf_evt, unf_evt, inv_evt, nan_evt;

  fpm_unpack u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .mode     (rmode_e'(rnd_mode)),
    .s1_valid (s1_valid),
    .s1_ctl   (s1_ctl),
    .s1_sig_a (s1_sig_a),
    .s1_sig_b (s1_sig_b)
  );

  fpm_sigmul u_sigmul (
    .clk      (clk),
    .rst_n    (rst_n),
    .s1_valid (s1_valid),
    .s1_ctl   (s1_ctl),
    .s1_sig_a (s1_sig_a),
    .s1_sig_b (s1_sig_b),
    .s2_valid (s2_valid),
    .s2_ctl   (s2_ctl),
    .s2_prod  (s2_prod)
  );

  fpm_round_pack u_round (
    .ctl      (s2_ctl),
    .prod     (s2_prod),
    .res_word (res_word),
    .ovf_evt  (ovf_evt),
    .unf_evt  (unf_evt),
    .inv_evt  (inv_evt),
    .nan_evt  (nan_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_ovf  <= 1'b0;
      flag_unf  <= 1'b0;
      flag_inv  <= 1'b0;
    end else begin
      out_valid <= s2_valid;
      result    <= s2_valid ? res_word : '0;
      flag_ovf  <= s2_valid & ovf_evt;
      flag_unf  <= s2_valid & unf_evt;
      flag_inv  <= s2_valid & inv_evt;
    end
  end
endmodule

// File: rtl/fp32_mul_core_chk.sv
module fp32_mul_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        out_valid,
  input logic [31:0] result,
  input logic        flag_ovf,
  input logic        flag_unf,
  input logic        flag_inv,
  input logic        ovf_evt,
  input logic        unf_evt,
  input logic        inv_evt,
  input logic        nan_evt
);
  logic [1:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd3);

  // R1
  latency_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 3)));

  // R10
  flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(flag_ovf || flag_unf || flag_inv));

  // R10
  flags_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_ovf, flag_unf, flag_inv}));

  // R10
  events_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_evt, unf_evt, inv_evt | nan_evt}));

  // R8
  invalid_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inv |-> (result == 32'h7FC0_0000));

  // R6
  underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_unf |-> (result[30:0] == 31'd0));

  // R5
  overflow_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf |-> ((result[30:0] == 31'h7F80_0000) || (result[30:0] == 31'h7F7F_FFFF)));

  // R4
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && result != 32'h7FC0_0000) |->
      (result[31] == $past(op_a[31] ^ op_b[31], 3)));
endmodule

bind fp32_mul_core fp32_mul_core_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .result    (result),
  .flag_ovf  (flag_ovf),
  .flag_unf  (flag_unf),
  .flag_inv  (flag_inv),
  .ovf_evt   (ovf_evt),
  .unf_evt   (unf_evt),
  .inv_evt   (inv_evt),
  .nan_evt   (nan_evt)
);

// File: tb/fp32_mul_core_tb_top.sv
module fp32_mul_core_tb_top;
  localparam int CLK_HALF = 4;
  localparam int N_RAND   = 3000;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  rnd_mode = '0;
  logic        out_valid, flag_ovf, flag_unf, flag_inv;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  logic [31:0] q_res [$];
  logic [2:0]  q_flg [$];
  int          q_cyc [$];
  string       q_tag [$];

  fp32_mul_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .rnd_mode(rnd_mode), .out_valid(out_valid), .result(result),
    .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_inv(flag_inv)
  );

  always #(CLK_HALF) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Independent model: scale the exact product to 24 bits, compare the dropped remainder with half.
  function automatic void ref_mul(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                                  output logic [31:0] r, output logic [2:0] flg);
    int     ea, eb, xa, xb, msb, k, ebias;
    longint ma, mb, p, kept, rem, half;
    logic   s, an, bn, ai, bi, az, bz, up;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    s  = a[31] ^ b[31];
    an = (ea == 255) && (a[22:0] != 0); bn = (eb == 255) && (b[22:0] != 0);
    ai = (ea == 255) && (a[22:0] == 0); bi = (eb == 255) && (b[22:0] == 0);
    az = (ea == 0) && (a[22:0] == 0);   bz = (eb == 0) && (b[22:0] == 0);
    flg = 3'b000;
    if (an || bn) begin
      r = 32'h7FC0_0000;
    end else if ((ai && bz) || (az && bi)) begin
      r = 32'h7FC0_0000; flg = 3'b001;
    end else if (ai || bi) begin
      r = {s, 8'hFF, 23'd0};
    end else if (az || bz) begin
      r = {s, 31'd0};
    end else begin
      ma = longint'(a[22:0]) + ((ea == 0) ? 64'd0 : (64'd1 << 23));
      mb = longint'(b[22:0]) + ((eb == 0) ? 64'd0 : (64'd1 << 23));
      xa = (ea == 0) ? 1 : ea;
      xb = (eb == 0) ? 1 : eb;
      p  = ma * mb;
      msb = 0;
      for (int i = 0; i < 48; i++) if (p[i]) msb = i;
      k = msb - 23;
      if (k > 0) begin
        kept = p >> k;
        rem  = p & ((64'd1 << k) - 1);
        half = 64'd1 << (k - 1);
      end else begin
        kept = p << (-k);
        rem  = 0;
        half = 1;
      end
      ebias = xa + xb - 150 + k;
      case (m)
        2'd0:    up = (rem > half) || ((rem == half) && kept[0]);
        2'd1:    up = 1'b0;
        2'd2:    up = (rem != 0) && !s;
        default: up = (rem != 0) && s;
      endcase
      if (up) kept = kept + 1;
      if (kept == (64'd1 << 24)) begin
        kept  = kept >> 1;
        ebias = ebias + 1;
      end
      if (ebias >= 255) begin
        flg = 3'b100;
        if (m == 2'd0 || (m == 2'd2 && !s) || (m == 2'd3 && s)) r = {s, 8'hFF, 23'd0};
        else r = {s, 8'hFE, 23'h7FFFFF};
      end else if (ebias <= 0) begin
        flg = 3'b010;
        r = {s, 31'd0};
      end else begin
        r = {s, ebias[7:0], kept[22:0]};
      end
    end
  endfunction

  function automatic logic [31:0] rnd_op();
    int sel, e;
    logic [22:0] f;
    sel = int'($urandom_range(0, 19));
    f   = 23'($urandom);
    if (sel < 11)       e = int'($urandom_range(90, 164));
    else if (sel == 11) e = 0;
    else if (sel == 12) begin e = 255; if ($urandom_range(0, 1) == 0) f = '0; end
    else if (sel == 13) begin e = 0; f = '0; end
    else if (sel == 14) e = int'($urandom_range(1, 20));
    else if (sel == 15) e = int'($urandom_range(230, 254));
    else if (sel == 16) begin e = int'($urandom_range(120, 134)); f = f & 23'h70_0000; end
    else                e = int'($urandom_range(1, 254));
    return {1'($urandom), e[7:0], f};
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                       input string tag);
    logic [31:0] r;
    logic [2:0]  flg;
    @(posedge clk); #1;
    op_a = a; op_b = b; rnd_mode = m; in_valid = 1'b1;
    ref_mul(a, b, m, r, flg);
    q_res.push_back(r);
    q_flg.push_back(flg);
    q_cyc.push_back(cyc);
    q_tag.push_back(tag);
  endtask

  task automatic bubble();
    @(posedge clk); #1;
    in_valid = 1'b0;
    op_a = 32'($urandom); op_b = 32'($urandom);
  endtask

  task automatic note_fail(input string tag, input string what, input logic [31:0] act,
                           input logic [31:0] exp);
    fails++;
    $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // output monitor, samples away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        checks++;
        if (q_res.size() == 0) begin
          note_fail("R1", "unexpected out_valid", 32'd1, 32'd0);
        end else begin
          logic [31:0] er;
          logic [2:0]  ef;
          int          ec;
          string       et;
          er = q_res.pop_front(); ef = q_flg.pop_front();
          ec = q_cyc.pop_front(); et = q_tag.pop_front();
          if (cyc != ec + 3) note_fail("R1", "latency", 32'(cyc - ec), 32'd3);
          else if (result !== er) note_fail(et, "result", result, er);
          else if ({flag_ovf, flag_unf, flag_inv} !== ef)
            note_fail(et, "flags ovf/unf/inv", {29'd0, flag_ovf, flag_unf, flag_inv}, {29'd0, ef});
        end
      end else begin
        checks++;
        // R10: quiet flags between results
        if ({flag_ovf, flag_unf, flag_inv} !== 3'b000)
          note_fail("R10", "flags while idle", {29'd0, flag_ovf, flag_unf, flag_inv}, 32'd0);
      end
    end
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!finished) begin
      checks++;
      note_fail("R1", "watchdog expired", 32'(cyc), 32'(WD_LIMIT));
      summary();
    end
  end

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({out_valid, flag_ovf, flag_unf, flag_inv} !== 4'b0 || result !== 32'd0)
      note_fail("R1", "reset state", {27'd0, out_valid, flag_ovf, flag_unf, flag_inv}, 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R2: exact and tie products in nearest-even
    issue(32'h3FC0_0000, 32'h3FC0_0000, 2'd0, "R2");
    issue(32'h3F80_0001, 32'h3FC0_0000, 2'd0, "R2");
    issue(32'h3F80_0001, 32'h3F80_0001, 2'd0, "R2");
    issue(32'h4049_0FDB, 32'hC02D_F854, 2'd0, "R2");
    // R3: directed modes on both signs
    for (int m = 1; m < 4; m++) begin
      issue(32'h3F80_0001, 32'h3FC0_0000, 2'(m), "R3");
      issue(32'hBF80_0001, 32'h3FC0_0000, 2'(m), "R3");
      issue(32'h3FFF_FFFF, 32'h3FFF_FFFF, 2'(m), "R3");
    end
    // R5: overflow in every mode and sign
    for (int m = 0; m < 4; m++) begin
      issue(32'h7F7F_FFFF, 32'h4000_0000, 2'(m), "R5");
      issue(32'hFF7F_FFFF, 32'h4000_0000, 2'(m), "R5");
    end
    // R6: underflow flushes to signed zero
    issue(32'h0080_0000, 32'h0080_0000, 2'd0, "R6");
    issue(32'h8080_0000, 32'h3F00_0000, 2'd2, "R6");
    // R7: NaN operands
    issue(32'h7FC0_0000, 32'h3F80_0000, 2'd0, "R7");
    issue(32'h7F80_0001, 32'h0000_0000, 2'd1, "R7");
    // R8: zero times infinity
    issue(32'h0000_0000, 32'h7F80_0000, 2'd0, "R8");
    issue(32'hFF80_0000, 32'h8000_0000, 2'd3, "R8");
    // R9: subnormal operands renormalized
    issue(32'h0000_0001, 32'h4B00_0000, 2'd0, "R9");
    issue(32'h0040_0000, 32'h4080_0000, 2'd0, "R9");
    issue(32'h0000_0003, 32'h3F00_0000, 2'd0, "R9");
    // R4 and R11: signed zero and signed infinity
    issue(32'h8000_0000, 32'h40A0_0000, 2'd0, "R11");
    issue(32'hFF80_0000, 32'h4000_0000, 2'd0, "R4");
    issue(32'h7F80_0000, 32'h8000_0001, 2'd0, "R11");
    bubble();
    bubble();

    // R2 and R3 under constrained random operands, with random idle gaps (R1)
    for (int i = 0; i < N_RAND; i++) begin
      issue(rnd_op(), rnd_op(), 2'($urandom), "R2/R3");
      if ($urandom_range(0, 3) == 0) bubble();
    end
    bubble();
    repeat (8) @(posedge clk);
    @(negedge clk);
    checks++;
    // R1: every issued operation produced exactly one output
    if (q_res.size() != 0) note_fail("R1", "missing outputs", 32'(q_res.size()), 32'd0);
    summary();
  end
endmodule